// File: doc/BRIEF.md
# All-Ones Alarm Detector

This block watches a recovered serial line, one bit for each strobe of a bit-enable input, and decides whether the far end is sending an all-ones alarm pattern. It splits the stream into back-to-back windows of a fixed number of bits and counts the zero bits inside each one. At the close of every window it makes a decision. Too few zeros means the line carries the alarm pattern. Enough zeros means normal traffic.

The block keeps a live alarm status bit, which also drives an output pin. It also keeps a sticky change flag that sets whenever the status flips in either direction. An active-low interrupt line is pulled low while the change flag is pending, unless a mask bit holds it off. A host reads the status and flag through a small strobe-based register port, clears the flag by writing a one, and sets or clears the mask. Detection only runs while the host-mode input is high. While host mode is low, the status, the flag and the interrupt stay inactive and the window restarts.

Top module: `ais_detector`

## Requirements
- R1: Bits are counted only on cycles where `bit_en` is high, in consecutive non-overlapping windows of `WINDOW_BITS` (default 2048) strobes. `ais_alarm` changes only on the clock edge that samples the last strobe of a window. In the middle of a window it holds its value.
- R2: A window that holds fewer than `ZERO_LIMIT` (default 3) zero bits sets `ais_alarm` to 1, or keeps it at 1.
- R3: A window that holds `ZERO_LIMIT` or more zeros sets `ais_alarm` to 0, or keeps it at 0. Any number of zeros at or above the limit gives the same result.
- R4: Each change of `ais_alarm`, from 0 to 1 or from 1 to 0, sets the change flag (status register bit 1) on the same edge. A window that leaves the status unchanged does not set it.
- R5: `irq_n` is low exactly when the change flag is 1 and the mask bit is 0. Otherwise it is high.
- R6: With the mask bit set to 1, a status change still sets the flag, but `irq_n` stays high. Clearing the mask while the flag is pending drives `irq_n` low.
- R7: Register map. Address 0 is the status register: read bit 0 is the alarm and read bit 1 is the change flag. Writes to address 0 have no effect. Address 1 is the control register: writing bit 0 as 1 clears the change flag, and write bit 1 stores the mask. Reading address 1 gives the mask in bit 1 and 0 in bit 0.
- R8: If a clear write and a status change occur on the same edge, the change wins and the flag stays 1.
- R9: After reset, the alarm is 0, the flag is 0, the mask is 0, `irq_n` is high and the window count starts at zero.
- R10: While `host_mode` is low, the alarm and the flag are forced to 0, `irq_n` is high, strobes are ignored and the window restarts. After `host_mode` returns high, the next decision comes after a full window of fresh strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_mode | input | 1 | Enables detection when high |
| bit_en | input | 1 | Strobe: `bit_in` holds a valid line bit this cycle |
| bit_in | input | 1 | Recovered line bit |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 status, 1 control |
| reg_wdata | input | 2 | Write data |
| reg_rdata | output | 2 | Read data for the selected register (combinational) |
| ais_alarm | output | 1 | Live alarm status |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bound checker checks four things on every cycle:
- the alarm moves only on the edge that completes a window;
- every status flip leaves the change flag set;
- a low interrupt always has a pending flag behind it;
- leaving host mode silences the status and the interrupt, and the window position never passes its last slot.

Other behaviour only shows up in the bench's scenarios. This covers the zero-count decision itself, both at the threshold and when zeros fall near the end of a window. It also covers saturation with many zeros, the mask hiding and then releasing the interrupt, clear-versus-change priority, and the window restarting after host mode returns.

// File: rtl/aisd_pkg.sv
package aisd_pkg;

    // Register select values on the one-bit address
    typedef enum logic {
        REG_STAT = 1'b0,
        REG_CTRL = 1'b1
    } reg_sel_e;

    // Field positions inside the two-bit register words
    localparam int STAT_ALARM_BIT = 0;
    localparam int STAT_FLAG_BIT  = 1;
    localparam int CTRL_CLR_BIT   = 0;
    localparam int CTRL_MASK_BIT  = 1;
    localparam int REG_W          = 2;

    // Host-visible state of the detector
    typedef struct packed {
        logic alarm;
        logic flag;
        logic mask;
    } stat_regs_t;

endpackage

// File: rtl/aisd_window.sv
module aisd_window #(
    parameter int WINDOW_BITS = 2048,
    parameter int ZERO_LIMIT  = 3,
    localparam int CNT_W      = $clog2(WINDOW_BITS),
    localparam int ZW         = $clog2(ZERO_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             bit_en,
    input  logic             bit_in,
    output logic             win_eval,
    output logic             win_short,
    output logic [CNT_W-1:0] win_pos
);

    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(WINDOW_BITS - 1);
    localparam logic [ZW-1:0]    ZMAX     = ZW'(ZERO_LIMIT);

    typedef struct packed {
        logic [CNT_W-1:0] pos;
        logic [ZW-1:0]    zeros;
    } win_state_t;

    win_state_t st_q, st_d;
    logic [ZW-1:0] zeros_inc;
    logic          at_last;

    always_comb begin
        // Zero tally including the current bit, saturating at the limit
        zeros_inc = st_q.zeros;
        if (bit_en && !bit_in && (st_q.zeros < ZMAX)) begin
            zeros_inc = st_q.zeros + ZW'(1);
        end
        at_last   = (st_q.pos == LAST_POS);
        win_eval  = run && bit_en && at_last;
        win_short = (zeros_inc < ZMAX);
        win_pos   = st_q.pos;

        st_d = st_q;
        if (!run) begin
            st_d = '0;
        end else if (bit_en) begin
            if (at_last) begin
                st_d = '0;
            end else begin
                st_d.pos   = st_q.pos + CNT_W'(1);
                st_d.zeros = zeros_inc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/aisd_status.sv
module aisd_status
    import aisd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic win_eval,
    input  logic win_short,
    input  logic flag_clr,
    input  logic mask_wr,
    input  logic mask_val,
    output logic alarm,
    output logic flag,
    output logic mask,
    output logic irq_n
);

    stat_regs_t rg_q, rg_d;
    logic       flips;

    always_comb begin
        flips = run && win_eval && (win_short != rg_q.alarm);
        rg_d  = rg_q;

        if (!run) begin
            rg_d.alarm = 1'b0;
            rg_d.flag  = 1'b0;
        end else begin
            if (win_eval) begin
                rg_d.alarm = win_short;
            end
            // A status flip outranks a clear on the same edge
            if (flips) begin
                rg_d.flag = 1'b1;
            end else if (flag_clr) begin
                rg_d.flag = 1'b0;
            end
        end

        if (mask_wr) begin
            rg_d.mask = mask_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    assign alarm = rg_q.alarm;
    assign flag  = rg_q.flag;
    assign mask  = rg_q.mask;
    assign irq_n = !(rg_q.flag && !rg_q.mask);

endmodule

// File: rtl/ais_detector.sv
module ais_detector
    import aisd_pkg::*;
#(
    parameter int WINDOW_BITS = 2048,
    parameter int ZERO_LIMIT  = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_mode,
    input  logic       bit_en,
    input  logic       bit_in,
    input  logic       reg_wr,
    input  logic       reg_addr,
    input  logic [1:0] reg_wdata,
    output logic [1:0] reg_rdata,
    output logic       ais_alarm,
    output logic       irq_n
);

    localparam int CNT_W = $clog2(WINDOW_BITS);

    logic             win_eval_w;
    logic             win_short_w;
    logic [CNT_W-1:0] win_pos_w;
    logic             flag_w;
    logic             mask_w;
    logic             ctrl_wr;
    logic             clr_w;

    aisd_window #(
        .WINDOW_BITS(WINDOW_BITS),
        .ZERO_LIMIT (ZERO_LIMIT)
    ) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (host_mode),
        .bit_en   (bit_en),
        .bit_in   (bit_in),
        .win_eval (win_eval_w),
        .win_short(win_short_w),
        .win_pos  (win_pos_w)
    );

    always_comb begin
        ctrl_wr = reg_wr && (reg_sel_e'(reg_addr) == REG_CTRL);
        clr_w   = ctrl_wr && reg_wdata[CTRL_CLR_BIT];
    end

    aisd_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (host_mode),
        .win_eval (win_eval_w),
        .win_short(win_short_w),
        .flag_clr (clr_w),
        .mask_wr  (ctrl_wr),
        .mask_val (reg_wdata[CTRL_MASK_BIT]),
        .alarm    (ais_alarm),
        .flag     (flag_w),
        .mask     (mask_w),
        .irq_n    (irq_n)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_sel_e'(reg_addr))
            REG_STAT: begin
                reg_rdata[STAT_ALARM_BIT] = ais_alarm;
                reg_rdata[STAT_FLAG_BIT]  = flag_w;
            end
            default: begin
                reg_rdata[CTRL_MASK_BIT] = mask_w;
            end
        endcase
    end

endmodule

// File: rtl/aisd_checker.sv
module aisd_checker #(
    parameter int WINDOW_BITS = 2048,
    localparam int CNT_W      = $clog2(WINDOW_BITS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_mode,
    input logic             alarm,
    input logic             flag,
    input logic             irq_n,
    input logic             win_eval,
    input logic [CNT_W-1:0] win_pos
);

    // R1: in host mode the status moves only on a window-closing edge
    a_r1_change_at_window_end: assert property (@(posedge clk) disable iff (!rst_n)
        (host_mode && (alarm != $past(alarm))) |-> $past(win_eval));

    // R1: window position never runs past its final slot
    a_r1_pos_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(win_pos) < WINDOW_BITS));

    // R4: every status flip leaves the change flag set
    a_r4_flip_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (host_mode && (alarm != $past(alarm))) |-> flag);

    // R5: a low interrupt needs a pending flag
    a_r5_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> flag);

    // R10: leaving host mode silences status and interrupt
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !host_mode |=> (!alarm && !flag && irq_n));

endmodule

bind ais_detector aisd_checker #(.WINDOW_BITS(WINDOW_BITS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_mode(host_mode),
    .alarm    (ais_alarm),
    .flag     (flag_w),
    .irq_n    (irq_n),
    .win_eval (win_eval_w),
    .win_pos  (win_pos_w)
);

// File: tb/ais_detector_test.sv
`timescale 1ns/1ps
module ais_detector_test;

    localparam int W  = 2048;
    localparam int ZL = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_mode = 1'b1;
    logic       bit_en = 1'b0;
    logic       bit_in = 1'b1;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [1:0] reg_wdata = 2'b00;
    logic [1:0] reg_rdata;
    logic       ais_alarm;
    logic       irq_n;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    // Bench model of the requirements
    int  m_bits = 0;
    int  m_zeros = 0;
    bit  m_alarm = 1'b0;
    bit  m_flag = 1'b0;
    bit  m_mask = 1'b0;
    bit  m_host = 1'b1;
    int  seed;
    logic [1:0] rd_val;

    ais_detector #(.WINDOW_BITS(W), .ZERO_LIMIT(ZL)) uut (
        .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .bit_en(bit_en),
        .bit_in(bit_in), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ais_alarm(ais_alarm), .irq_n(irq_n)
    );

    always #2.5 clk = ~clk;

    function automatic bit exp_irq_n(bit flag, bit mask);
        return !(flag && !mask);
    endfunction

    task automatic chk(string req, int actual, int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic rd(input logic addr, output logic [1:0] val);
        @(negedge clk);
        reg_addr = addr;
        #1;
        val = reg_rdata;
    endtask

    task automatic wr(input logic addr, input logic [1:0] data);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_addr = addr;
        reg_wdata = data;
        @(posedge clk);
        #1;
        reg_wr = 1'b0;
        if (addr == 1'b1) begin
            if (data[0] && m_host) m_flag = 1'b0;
            m_mask = data[1];
        end
    endtask

    // One line bit; optionally a flag-clear write on the same edge
    task automatic strobe(input bit b, input bit clr);
        @(negedge clk);
        bit_en = 1'b1;
        bit_in = b;
        if (clr) begin
            reg_wr = 1'b1;
            reg_addr = 1'b1;
            reg_wdata = {m_mask, 1'b1};
        end
        @(posedge clk);
        #1;
        bit_en = 1'b0;
        reg_wr = 1'b0;
        if (m_host) begin
            if (clr) m_flag = 1'b0;
            if (!b && m_zeros < ZL) m_zeros++;
            m_bits++;
            if (m_bits == W) begin
                if ((m_zeros < ZL) != m_alarm) begin
                    m_alarm = (m_zeros < ZL);
                    m_flag = 1'b1;
                end
                m_bits = 0;
                m_zeros = 0;
            end
        end
    endtask

    // k zeros spread at stride W/k, starting at offset off
    task automatic send_window(input int k, input int off, input bit clr_last);
        int stride;
        stride = (k > 0) ? W / k : W;
        for (int i = 0; i < W; i++) begin
            bit b;
            b = !(k > 0 && (i % stride) == off && (i / stride) < k);
            strobe(b, clr_last && (i == W - 1));
            if (i == W / 2) chk("R1 alarm holds mid-window", ais_alarm, m_alarm);
        end
    endtask

    task automatic check_state(string req);
        chk({req, " alarm"}, ais_alarm, m_alarm);
        rd(1'b0, rd_val);
        chk({req, " status alarm bit"}, rd_val[0], m_alarm);
        chk({req, " status flag bit"}, rd_val[1], m_flag);
        chk({req, " irq_n"}, irq_n, exp_irq_n(m_flag, m_mask));
    endtask

    initial begin
        seed = $urandom(32'd4242);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R9: reset state
        check_state("R9 reset");
        rd(1'b1, rd_val);
        chk("R9 mask after reset", rd_val, 0);

        // R2 R4 R5: all ones sets the alarm, flag, interrupt
        send_window(0, 0, 1'b0);
        chk("R2 alarm set on zero-free window", ais_alarm, 1);
        check_state("R4 R5 after set");

        // R7: write-one-to-clear
        wr(1'b1, 2'b01);
        check_state("R7 after clear");
        chk("R7 flag cleared", m_flag, 0);

        // R2: two zeros keeps alarm, no new flag
        send_window(2, 100, 1'b0);
        check_state("R2 two zeros keep alarm");

        // R3: three zeros near end clears alarm
        send_window(3, W / 3 - 1, 1'b0);
        chk("R3 alarm cleared by three zeros", ais_alarm, 0);
        check_state("R3 R4 after clear");
        wr(1'b1, 2'b01);

        // R3: saturation with many zeros
        send_window(40, 7, 1'b0);
        check_state("R3 many zeros");

        // R2: single zero at the last bit of the window still sets alarm
        send_window(1, W - 1, 1'b0);
        check_state("R2 lone zero at last bit");

        // R6: masked interrupt
        wr(1'b1, 2'b11);
        rd(1'b1, rd_val);
        chk("R7 mask reads back", rd_val, 2);
        send_window(5, 3, 1'b0);
        check_state("R6 masked change");
        chk("R6 irq_n stays high while masked", irq_n, 1);
        wr(1'b1, 2'b00);
        check_state("R6 unmasked");
        chk("R6 irq_n low after unmask", irq_n, 0);
        wr(1'b1, 2'b01);

        // R8: change and clear on the same edge
        send_window(0, 0, 1'b1);
        check_state("R8 change beats clear");
        chk("R8 flag kept", m_flag, 1);

        // R7: writes to status address ignored
        wr(1'b0, 2'b11);
        check_state("R7 status write ignored");
        rd(1'b1, rd_val);
        chk("R7 mask untouched by status write", rd_val, 0);

        // R10: host mode off mid-window
        for (int i = 0; i < 700; i++) strobe(1'b1, 1'b0);
        @(negedge clk);
        host_mode = 1'b0;
        @(posedge clk);
        #1;
        m_host = 1'b0;
        m_alarm = 1'b0;
        m_flag = 1'b0;
        m_bits = 0;
        m_zeros = 0;
        check_state("R10 host off");
        for (int i = 0; i < W + 10; i++) strobe(1'b1, 1'b0);
        check_state("R10 strobes ignored");
        @(negedge clk);
        host_mode = 1'b1;
        m_host = 1'b1;
        for (int i = 0; i < W - 1; i++) strobe(1'b1, 1'b0);
        chk("R10 no decision before full fresh window", ais_alarm, 0);
        strobe(1'b1, 1'b0);
        chk("R10 decision after full fresh window", ais_alarm, 1);
        check_state("R10 resumed");

        // Random windows
        for (int n = 0; n < 10; n++) begin
            int ks [6] = '{0, 1, 2, 3, 4, 9};
            int k;
            int st;
            k = ks[$urandom_range(5)];
            st = (k > 0) ? W / k : W;
            if ($urandom_range(3) == 0) wr(1'b1, {1'($urandom_range(1)), 1'b1});
            send_window(k, $urandom_range(st - 1), 1'($urandom_range(4) == 0));
            check_state(k < ZL ? "R2 random window" : "R3 random window");
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule